// File: doc/BRIEF.md
# Two-Way Write-Back Set-Associative Byte Cache

This block is a small data cache placed between a processor's byte-wide load/store port and a backing memory that moves whole 32-bit words. A 16-bit byte address is split into a 6-bit tag, an 8-bit set index and a 2-bit byte offset. Each of the 256 sets holds two ways. Each way has its own valid bit, dirty bit and tag, and each set has one replacement bit. The total metadata is 256 × (1 + 2 × 8) = 4352 bits.

Hits are answered from the data array with no memory traffic. On a miss, the way named by the set's replacement bit is the victim. If the victim is dirty, its whole block is first written back to memory. The block is then refilled from memory. A write miss allocates the block first and then merges the byte into it. The processor holds its request until it sees a single-cycle `cpu_ready` pulse. The memory side holds its request until it sees `mem_ready`.

Top module: `cache2w`

## Requirements
- R1: Address fields are tag = addr[15:10], set = addr[9:2] and offset = addr[1:0]. `mem_addr` carries the block address {tag, set}. Byte k of a block travels on bits [8k+7:8k] of the memory word.
- R2: After reset, `cpu_ready` and `mem_req` are low and every valid and dirty bit is clear, so the first access to any address misses.
- R3: A read hit returns the addressed byte with `cpu_ready` at the second rising edge after the request is presented, and raises no `mem_req`.
- R4: A write hit changes only the addressed byte of the block, marks the way dirty and causes no memory traffic.
- R5: A read miss with a clean or invalid victim issues exactly one memory read of the requested block and returns the addressed byte from it.
- R6: A write miss allocates the block with one memory read. The other three bytes keep their memory values and the addressed byte takes the write data.
- R7: The per-set replacement bit names the way to evict next. It is 0 after reset, and a hit or a completed refill on way w sets it to the other way.
- R8: Evicting a valid dirty way writes the whole victim block to the victim's block address before the refill read. A clean victim causes no write.
- R9: While a miss is in progress `cpu_ready` stays low, and each request gets exactly one single-cycle `cpu_ready` pulse. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay steady until `mem_ready` is seen.
- R10: The two ways of one set hold blocks with different tags at the same time, and both hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request, held until `mem_ready` |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | 14 | Block address |
| mem_wdata | output | 32 | Write-back block |
| mem_rdata | input | 32 | Refill block, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completion |

## Verification
The bench drives three tags through set 0 so that a clean way, a dirty way and a freshly hit way each become the victim in turn. A design with an inverted replacement bit would evict the way that was just used. A design that skipped the write-back would later return stale bytes for the evicted block. The bench also checks that the write-back comes before the refill, goes to the victim's block address and carries the merged bytes. Write-allocate is checked on all four bytes, which catches a merge that clobbers neighbouring bytes or that drops the written byte. The top set with the top tag and offset 3 is exercised so that a mis-sliced field or a truncated address shows up as the wrong data or the wrong `mem_addr`.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int WAYS = 2;
  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WB, S_FILL} cstate_t;
endpackage

// File: rtl/cache_ram.sv
module cache_ram #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rd <= mem[addr];
  end
endmodule

// File: rtl/cache_meta.sv
module cache_meta #(
  parameter int IDX_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [IDX_W-1:0]          idx,
  input  logic                      acc_en,
  input  logic                      acc_way,
  input  logic                      acc_fill,
  input  logic                      acc_write,
  output logic [cache_pkg::WAYS-1:0] valid_o,
  output logic [cache_pkg::WAYS-1:0] dirty_o,
  output logic                      lru_o
);
  localparam int NSETS = 1 << IDX_W;
  logic [NSETS-1:0] lru_q;

  for (genvar w = 0; w < cache_pkg::WAYS; w++) begin : g_way
    logic [NSETS-1:0] v_q, d_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= '0;
        d_q <= '0;
      end else if (acc_en && acc_way == 1'(w)) begin
        if (acc_fill) begin
          v_q[idx] <= 1'b1;
          d_q[idx] <= acc_write;
        end else begin
          d_q[idx] <= d_q[idx] | acc_write;
        end
      end
    end
    assign valid_o[w] = v_q[idx];
    assign dirty_o[w] = d_q[idx];

    assert_dirty_valid_R8: assert property (@(posedge clk) disable iff (rst)
      d_q[idx] |-> v_q[idx]);
  end

  always_ff @(posedge clk) begin
    if (rst) lru_q <= '0;
    else if (acc_en) lru_q[idx] <= ~acc_way;
  end
  assign lru_o = lru_q[idx];

  assert_lru_flip_R7: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> (lru_o != $past(acc_way)));
endmodule

// File: rtl/cache2w.sv
module cache2w #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cpu_req,
  input  logic                          cpu_we,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [7:0]                    cpu_wdata,
  output logic [7:0]                    cpu_rdata,
  output logic                          cpu_ready,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [ADDR_W-OFF_W-1:0]       mem_addr,
  output logic [8*(1<<OFF_W)-1:0]       mem_wdata,
  input  logic [8*(1<<OFF_W)-1:0]       mem_rdata,
  input  logic                          mem_ready
);
  import cache_pkg::*;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = 8 * (1 << OFF_W);

  function automatic logic [7:0] get_byte(logic [LINE_W-1:0] w, logic [OFF_W-1:0] o);
    return w[8*o +: 8];
  endfunction
  function automatic logic [LINE_W-1:0] put_byte(logic [LINE_W-1:0] w, logic [OFF_W-1:0] o,
                                                 logic [7:0] b);
    logic [LINE_W-1:0] r;
    r = w;
    r[8*o +: 8] = b;
    return r;
  endfunction

  cstate_t          st;
  logic [TAG_W-1:0] tag_l;
  logic [IDX_W-1:0] idx_l;
  logic [OFF_W-1:0] off_l;
  logic             we_l;
  logic [7:0]       wd_l;

  logic             accept;
  logic [IDX_W-1:0] ram_addr;
  logic [WAYS-1:0]  data_we, tag_we;
  logic [LINE_W-1:0] data_wd;
  logic [LINE_W-1:0] data_q [WAYS];
  logic [TAG_W-1:0]  tag_q  [WAYS];
  logic [WAYS-1:0]  m_valid, m_dirty, hit_w;
  logic             m_lru, hit, hit_way, victim, vict_dirty;
  logic             acc_en, acc_way, acc_fill;

  assign accept   = (st == S_IDLE) && cpu_req && !cpu_ready;
  assign ram_addr = (st == S_IDLE) ? cpu_addr[OFF_W +: IDX_W] : idx_l;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cache_ram #(.W(LINE_W), .AW(IDX_W)) u_data (
      .clk(clk), .we(data_we[w]), .re(accept), .addr(ram_addr),
      .wd(data_wd), .rd(data_q[w]));
    cache_ram #(.W(TAG_W), .AW(IDX_W)) u_tag (
      .clk(clk), .we(tag_we[w]), .re(accept), .addr(ram_addr),
      .wd(tag_l), .rd(tag_q[w]));
    assign hit_w[w] = m_valid[w] && (tag_q[w] == tag_l);
  end

  assign hit        = |hit_w;
  assign hit_way    = hit_w[1];
  assign victim     = m_lru;
  assign vict_dirty = m_valid[victim] && m_dirty[victim];

  always_comb begin
    data_we  = '0;
    tag_we   = '0;
    data_wd  = mem_rdata;
    acc_en   = 1'b0;
    acc_way  = hit_way;
    acc_fill = 1'b0;
    if (st == S_LOOK && hit) begin
      acc_en = 1'b1;
      if (we_l) begin
        data_we[hit_way] = 1'b1;
        data_wd = put_byte(data_q[hit_way], off_l, wd_l);
      end
    end else if (st == S_FILL && mem_ready) begin
      acc_en   = 1'b1;
      acc_way  = victim;
      acc_fill = 1'b1;
      data_we[victim] = 1'b1;
      tag_we[victim]  = 1'b1;
      data_wd = we_l ? put_byte(mem_rdata, off_l, wd_l) : mem_rdata;
    end
  end

  cache_meta #(.IDX_W(IDX_W)) u_meta (
    .clk(clk), .rst(rst), .idx(idx_l), .acc_en(acc_en), .acc_way(acc_way),
    .acc_fill(acc_fill), .acc_write(we_l), .valid_o(m_valid), .dirty_o(m_dirty),
    .lru_o(m_lru));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      tag_l     <= '0;
      idx_l     <= '0;
      off_l     <= '0;
      we_l      <= 1'b0;
      wd_l      <= '0;
    end else begin
      cpu_ready <= 1'b0;
      unique case (st)
        S_IDLE: if (accept) begin
          tag_l <= cpu_addr[ADDR_W-1 -: TAG_W];
          idx_l <= cpu_addr[OFF_W +: IDX_W];
          off_l <= cpu_addr[OFF_W-1:0];
          we_l  <= cpu_we;
          wd_l  <= cpu_wdata;
          st    <= S_LOOK;
        end
        S_LOOK: begin
          if (hit) begin
            if (!we_l) cpu_rdata <= get_byte(data_q[hit_way], off_l);
            cpu_ready <= 1'b1;
            st        <= S_IDLE;
          end else if (vict_dirty) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= {tag_q[victim], idx_l};
            mem_wdata <= data_q[victim];
            st        <= S_WB;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= {tag_l, idx_l};
            st       <= S_FILL;
          end
        end
        S_WB: if (mem_ready) begin
          mem_we   <= 1'b0;
          mem_addr <= {tag_l, idx_l};
          st       <= S_FILL;
        end
        S_FILL: if (mem_ready) begin
          mem_req   <= 1'b0;
          cpu_ready <= 1'b1;
          if (!we_l) cpu_rdata <= get_byte(mem_rdata, off_l);
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_reset_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!cpu_ready && !mem_req));
  assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));
  assert_wb_then_fill_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ready) |=>
      (mem_req && !mem_we && mem_addr[IDX_W-1:0] == $past(mem_addr[IDX_W-1:0])));
  assert_hit_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOOK && hit) |=> !mem_req);
endmodule

// File: tb/cache2w_test.sv
module cache2w_test;
  localparam int LAT = 3;
  logic clk = 0, rst = 1;
  logic cpu_req = 0, cpu_we = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0, cpu_rdata;
  logic cpu_ready, mem_req, mem_we, mem_ready;
  logic [13:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  cache2w uut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] bmem [int];
  logic [7:0]  shadow [int];
  logic        log_we [8];
  logic [13:0] log_addr [8];
  logic [31:0] log_data [8];
  int nlog = 0, lat = 0;
  bit stall_bad = 0;

  function automatic logic [31:0] init_word(int blk);
    return (32'(blk) * 32'h9E3779B1) ^ 32'hC0FFEE11;
  endfunction
  function automatic logic [31:0] rd_word(int blk);
    return bmem.exists(blk) ? bmem[blk] : init_word(blk);
  endfunction
  function automatic logic [7:0] exp_byte(int a);
    logic [31:0] w;
    if (shadow.exists(a)) return shadow[a];
    w = init_word(a >> 2);
    return w[8*(a & 3) +: 8];
  endfunction
  function automatic logic [31:0] exp_word(int blk);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = exp_byte(blk*4 + k);
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mem_ready <= 0; lat <= 0; mem_rdata <= '0;
    end else if (mem_ready) begin
      mem_ready <= 0; lat <= 0;
    end else if (mem_req) begin
      if (lat == LAT) begin
        mem_ready <= 1;
        if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
        else mem_rdata <= rd_word(int'(mem_addr));
        if (nlog < 8) begin
          log_we[nlog] = mem_we; log_addr[nlog] = mem_addr; log_data[nlog] = mem_wdata;
        end
        nlog = nlog + 1;
      end else lat <= lat + 1;
    end
    if (!rst && cpu_ready && mem_req) stall_bad = 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        finish_run();
      end
    end
  end

  task automatic access(input logic we, input logic [15:0] a, input logic [7:0] d,
                        output logic [7:0] q, output int cyc);
    nlog = 0;
    cyc = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 200);
    q = cpu_rdata;
    cpu_req = 0;
    if (we) shadow[int'(a)] = d;
    @(negedge clk);
    chk("R9 ready pulse single", {31'd0, cpu_ready}, 0);
  endtask

  task automatic rd_chk(input logic [15:0] a, input string req);
    logic [7:0] q; int c;
    access(0, a, 0, q, c);
    chk(req, q, exp_byte(int'(a)));
  endtask

  task automatic t_reset();
    logic [7:0] q; int c;
    chk("R2 cpu_ready low after reset", {31'd0, cpu_ready}, 0);
    chk("R2 mem_req low after reset", {31'd0, mem_req}, 0);
    access(0, 16'h0003, 0, q, c);
    chk("R2 R5 first read misses, one op", nlog, 1);
    chk("R5 refill is a read", {31'd0, log_we[0]}, 0);
    chk("R1 R5 refill block address", {18'd0, log_addr[0]}, 0);
    chk("R1 R5 byte 3 from memory word", q, exp_byte(3));
    chk("R9 miss stalls past latency", {31'd0, c > LAT}, 1);
  endtask

  task automatic t_read_hit();
    logic [7:0] q; int c;
    access(0, 16'h0001, 0, q, c);
    chk("R3 hit no memory traffic", nlog, 0);
    chk("R3 hit ready at second edge", c, 2);
    chk("R1 R3 hit byte 1", q, exp_byte(1));
  endtask

  task automatic t_write_hit();
    logic [7:0] q; int c;
    access(1, 16'h0001, 8'h5A, q, c);
    chk("R4 write hit no traffic", nlog, 0);
    for (int k = 0; k < 4; k++) rd_chk(16'(k), "R4 only addressed byte changed");
    chk("R4 rereads stay hits", nlog, 0);
  endtask

  task automatic t_write_alloc();
    logic [7:0] q; int c;
    access(1, 16'h1235, 8'hC3, q, c);
    chk("R6 write miss one op", nlog, 1);
    chk("R6 allocate is read", {31'd0, log_we[0]}, 0);
    chk("R6 allocate block addr", {18'd0, log_addr[0]}, 32'h48D);
    for (int k = 0; k < 4; k++) rd_chk(16'h1234 + 16'(k), "R6 merged block bytes");
  endtask

  task automatic t_lru_evict();
    logic [7:0] q; int c;
    rd_chk(16'h0400, "R5 R10 second tag same set");
    chk("R7 clean fill of way1 no write", nlog, 1);
    rd_chk(16'h0002, "R10 first way still hits");
    chk("R10 both ways hit", nlog, 0);
    rd_chk(16'h0800, "R7 third tag fills");
    chk("R7 R8 clean victim no write", nlog, 1);
    chk("R7 victim not way just hit", {31'd0, log_we[0]}, 0);
    rd_chk(16'h0401, "R7 evicted tag refetched");
    chk("R8 dirty victim two ops", nlog, 2);
    chk("R8 write-back first", {31'd0, log_we[0]}, 1);
    chk("R8 write-back victim block addr", {18'd0, log_addr[0]}, 0);
    chk("R8 write-back whole block", log_data[0], exp_word(0));
    chk("R8 then refill read", {18'd0, log_addr[1]}, 32'h100);
    rd_chk(16'h0803, "R7 R10 recent fill kept");
    chk("R7 hit after eviction", nlog, 0);
    rd_chk(16'h0001, "R8 written-back byte read from memory");
    chk("R8 clean victim no write", nlog, 1);
  endtask

  task automatic t_top_addr();
    logic [7:0] q; int c;
    access(1, 16'hFFFF, 8'hE7, q, c);
    chk("R1 top block addr", {18'd0, log_addr[0]}, 32'h3FFF);
    for (int k = 0; k < 4; k++) rd_chk(16'hFFFC + 16'(k), "R1 R6 top block bytes");
    rd_chk(16'h03FF, "R10 set 255 second way");
    rd_chk(16'h07FE, "R8 top set dirty eviction");
    chk("R8 top eviction write addr", {18'd0, log_addr[0]}, 32'h3FFF);
    chk("R8 top eviction data", log_data[0], exp_word(16'h3FFF));
    chk("R9 no ready during miss", {31'd0, stall_bad}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_read_hit();
    t_write_hit();
    t_write_alloc();
    t_lru_evict();
    t_top_addr();
    finish_run();
  end
endmodule